// File: doc/BRIEF.md
# Level-Sensitive Interrupt Combiner with Register Access

This block gathers between 2 and 64 level-sensitive interrupt lines into one interrupt request for a parent processor or controller. Each line first crosses a two-stage synchronizer into the bus clock domain. It is then qualified by a per-line enable bit and a per-line suppress bit. The qualified lines are ORed into one output. Software reaches the block through an APB slave port with no wait states. Sources 0 to 31 live in a lower 32-bit word of each register, and sources 32 to 63 live in an upper word placed 4 bytes above it.

Bits for sources that are not built have no storage and always read back as zero. A driver can therefore learn the line count by writing all ones to the enable words and reading them back. Two read-only views are provided. The qualified view is what drives the output. The enabled view ignores the suppress bits, so a driver can see pending lines even while they are suppressed.

Top module: `irq_combiner`

## Requirements
- R1: After reset every enable and suppress bit is 0, the output `irqOut` is low and all readable words return 0.
- R2: Enable words sit at byte offsets 0x00 (sources 0–31, bit n = source n) and 0x04 (bit n = source 32+n). They read back what was written. A line whose enable bit is 0 never shows in either status view and never drives `irqOut`.
- R3: Suppress words sit at 0x08 (sources 0–31) and 0x0C (sources 32–63), with the same bit layout as the enable words. A 1 blocks the line and a 0 lets it through.
- R4: The qualified status words at 0x30 (low) and 0x34 (high) read synchronized input AND enable AND NOT suppress. They are read-only, and writes to them change nothing.
- R5: The enabled status words at 0x20 (low) and 0x24 (high) read synchronized input AND enable. The suppress bits have no effect on them.
- R6: `irqOut` is high exactly when at least one qualified status bit is 1.
- R7: Every register and status bit for a source index at or above NUM_SRC reads 0. After all ones are written to the enable or suppress words, the readback holds ones only for the built sources.
- R8: A change on a source line reaches the status views and `irqOut` after exactly two rising clock edges.
- R9: Status follows the input level. A bit stays 1 as long as its line is high, falls once the line drops, and is not cleared by any write.
- R10: `pready` is always 1 and `pslverr` always 0. Read data is valid in the access phase of the transfer.
- R11: Reads of any offset not listed above, or of any address that is not word-aligned, return 0. Writes to such addresses change no register.
- R12: A register is written only in the access phase (`psel`, `penable` and `pwrite` all high). A setup-phase cycle or an unselected cycle writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and logic clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer complete, tied high |
| pslverr | output | 1 | Error response, tied low |
| srcIrq | input | NUM_SRC | Level-sensitive interrupt inputs |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with NUM_SRC = 40 and an 8-bit address. With this count the lower word is fully built and the upper word holds only eight live bits. One build therefore covers both the full-word path and the partly absent word behind the ones-write discovery. An 8-bit address also leaves room for unused word offsets above and between the defined registers, and for unaligned addresses. The bench uses these to check that undefined accesses are ignored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Word indices (byte offset / 4) of the register file
  localparam int WIDX_EN_LO  = 0;
  localparam int WIDX_EN_HI  = 1;
  localparam int WIDX_MSK_LO = 2;
  localparam int WIDX_MSK_HI = 3;
  localparam int WIDX_RAW_LO = 8;
  localparam int WIDX_RAW_HI = 9;
  localparam int WIDX_FIN_LO = 12;
  localparam int WIDX_FIN_HI = 13;

  localparam int WORD_W = 32;
  localparam int MAX_SRC = 64;

  typedef struct packed {
    logic enLo;
    logic enHi;
    logic mskLo;
    logic mskHi;
  } wrStrobe_t;

  typedef enum logic [3:0] {
    SEL_NONE   = 4'd0,
    SEL_EN_LO  = 4'd1,
    SEL_EN_HI  = 4'd2,
    SEL_MSK_LO = 4'd3,
    SEL_MSK_HI = 4'd4,
    SEL_RAW_LO = 4'd5,
    SEL_RAW_HI = 4'd6,
    SEL_FIN_LO = 4'd7,
    SEL_FIN_HI = 4'd8
  } rdSel_t;

endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output wrStrobe_t         wrStb,
  output rdSel_t            rdSel
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] wordIdx;
  logic              aligned;
  rdSel_t            regSel;
  logic              wrAccess;
  logic              rdAccess;

  assign wordIdx  = paddr[ADDR_W-1:2];
  assign aligned  = (paddr[1:0] == 2'b00);
  assign wrAccess = psel && penable && pwrite;
  assign rdAccess = psel && !pwrite;

  // Address decode: unaligned or unlisted offsets map to SEL_NONE
  always_comb begin
    regSel = SEL_NONE;
    if (aligned) begin
      if      (wordIdx == WIDX_W'(WIDX_EN_LO))  regSel = SEL_EN_LO;
      else if (wordIdx == WIDX_W'(WIDX_EN_HI))  regSel = SEL_EN_HI;
      else if (wordIdx == WIDX_W'(WIDX_MSK_LO)) regSel = SEL_MSK_LO;
      else if (wordIdx == WIDX_W'(WIDX_MSK_HI)) regSel = SEL_MSK_HI;
      else if (wordIdx == WIDX_W'(WIDX_RAW_LO)) regSel = SEL_RAW_LO;
      else if (wordIdx == WIDX_W'(WIDX_RAW_HI)) regSel = SEL_RAW_HI;
      else if (wordIdx == WIDX_W'(WIDX_FIN_LO)) regSel = SEL_FIN_LO;
      else if (wordIdx == WIDX_W'(WIDX_FIN_HI)) regSel = SEL_FIN_HI;
    end
  end

  always_comb begin
    wrStb.enLo  = wrAccess && (regSel == SEL_EN_LO);
    wrStb.enHi  = wrAccess && (regSel == SEL_EN_HI);
    wrStb.mskLo = wrAccess && (regSel == SEL_MSK_LO);
    wrStb.mskHi = wrAccess && (regSel == SEL_MSK_HI);
    rdSel       = rdAccess ? regSel : SEL_NONE;
  end

  // R12: at most one register strobe per cycle
  p_one_strobe_r12: assert property (@(posedge pclk) disable iff (!presetn)
    $onehot0({wrStb.enLo, wrStb.enHi, wrStb.mskLo, wrStb.mskHi}));

  // R12: a write cycle never selects read data
  p_write_no_read_r12: assert property (@(posedge pclk) disable iff (!presetn)
    pwrite |-> (rdSel == SEL_NONE));

  // R12: no strobe outside an access phase
  p_setup_silent_r12: assert property (@(posedge pclk) disable iff (!presetn)
    (!psel || !penable) |-> ({wrStb.enLo, wrStb.enHi, wrStb.mskLo, wrStb.mskHi} == 4'b0));

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic               pclk,
  input  logic               presetn,
  input  wrStrobe_t          wrStb,
  input  rdSel_t             rdSel,
  input  logic [31:0]        pwdata,
  input  logic [NUM_SRC-1:0] srcIrq,
  output logic [31:0]        prdata,
  output logic               irqOut
);

  localparam logic [MAX_SRC-1:0] IMPL =
    (NUM_SRC >= MAX_SRC) ? {MAX_SRC{1'b1}} : ((MAX_SRC'(1) << NUM_SRC) - MAX_SRC'(1));

  logic [NUM_SRC-1:0] enReg, mskReg;
  logic [NUM_SRC-1:0] syncA, syncB;
  logic [NUM_SRC-1:0] enWrVec, mskWrVec, wdRep;
  logic [NUM_SRC-1:0] rawVec, finVec;
  logic [MAX_SRC-1:0] enW, mskW, rawW, finW;
  logic               aliveQ;

  // Per-source write steering: lower word for sources 0..31, upper for 32..63
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (g < WORD_W) begin : g_lo
      assign enWrVec[g]  = wrStb.enLo;
      assign mskWrVec[g] = wrStb.mskLo;
      assign wdRep[g]    = pwdata[g];
    end else begin : g_hi
      assign enWrVec[g]  = wrStb.enHi;
      assign mskWrVec[g] = wrStb.mskHi;
      assign wdRep[g]    = pwdata[g-WORD_W];
    end
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      enReg  <= '0;
      mskReg <= '0;
      aliveQ <= 1'b0;
    end else begin
      enReg  <= (enReg & ~enWrVec) | (wdRep & enWrVec);
      mskReg <= (mskReg & ~mskWrVec) | (wdRep & mskWrVec);
      aliveQ <= 1'b1;
    end
  end

  // Two-stage input synchronizer
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= srcIrq;
      syncB <= syncA;
    end
  end

  assign rawVec = syncB & enReg;
  assign finVec = rawVec & ~mskReg;
  assign irqOut = |finVec;

  // Zero-extend to a full two-word view; absent sources are constant zero
  always_comb begin
    enW  = '0;
    mskW = '0;
    rawW = '0;
    finW = '0;
    enW[NUM_SRC-1:0]  = enReg;
    mskW[NUM_SRC-1:0] = mskReg;
    rawW[NUM_SRC-1:0] = rawVec;
    finW[NUM_SRC-1:0] = finVec;
  end

  always_comb begin
    unique case (rdSel)
      SEL_EN_LO:  prdata = enW[31:0];
      SEL_EN_HI:  prdata = enW[63:32];
      SEL_MSK_LO: prdata = mskW[31:0];
      SEL_MSK_HI: prdata = mskW[63:32];
      SEL_RAW_LO: prdata = rawW[31:0];
      SEL_RAW_HI: prdata = rawW[63:32];
      SEL_FIN_LO: prdata = finW[31:0];
      SEL_FIN_HI: prdata = finW[63:32];
      default:    prdata = '0;
    endcase
  end

  // R2: a low enable write lands as the written value, trimmed to built sources
  p_en_lo_write_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (aliveQ && $past(wrStb.enLo)) |-> (enW[31:0] == ($past(pwdata) & IMPL[31:0])));

  // R3: an upper suppress write lands likewise
  p_msk_hi_write_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (aliveQ && $past(wrStb.mskHi)) |-> (mskW[63:32] == ($past(pwdata) & IMPL[63:32])));

  // R11: without a strobe the control bits hold
  p_quiet_bus_r11: assert property (@(posedge pclk) disable iff (!presetn)
    (aliveQ && ($past({wrStb.enLo, wrStb.enHi, wrStb.mskLo, wrStb.mskHi}) == 4'b0))
      |-> ($stable(enReg) && $stable(mskReg)));

  // R8: an output request traces back to an input seen two edges earlier
  p_irq_origin_r8: assert property (@(posedge pclk) disable iff (!presetn)
    irqOut |-> (|($past(srcIrq, 2) & enReg & ~mskReg)));

  // R7: absent source bits never appear on the read bus
  p_absent_hi_r7: assert property (@(posedge pclk) disable iff (!presetn)
    ((rdSel == SEL_EN_HI) || (rdSel == SEL_MSK_HI) || (rdSel == SEL_RAW_HI) ||
     (rdSel == SEL_FIN_HI)) |-> ((prdata & ~IMPL[63:32]) == 32'h0));

  p_absent_lo_r7: assert property (@(posedge pclk) disable iff (!presetn)
    ((rdSel == SEL_EN_LO) || (rdSel == SEL_MSK_LO) || (rdSel == SEL_RAW_LO) ||
     (rdSel == SEL_FIN_LO)) |-> ((prdata & ~IMPL[31:0]) == 32'h0));

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 8
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic [NUM_SRC-1:0] srcIrq,
  output logic               irqOut
);

  wrStrobe_t wrStb;
  rdSel_t    rdSel;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  irqc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .pclk    (pclk),
    .presetn (presetn),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .wrStb   (wrStb),
    .rdSel   (rdSel)
  );

  irqc_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .pclk    (pclk),
    .presetn (presetn),
    .wrStb   (wrStb),
    .rdSel   (rdSel),
    .pwdata  (pwdata),
    .srcIrq  (srcIrq),
    .prdata  (prdata),
    .irqOut  (irqOut)
  );

endmodule

// File: tb/irq_combiner_tb.sv
module irq_combiner_tb;

  localparam int NSRC = 40;
  localparam logic [31:0] HI_BUILT = 32'h0000_00FF;

  logic        clk = 1'b0;
  logic        rstN;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [NSRC-1:0] src;
  logic        irqOut;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_combiner #(.NUM_SRC(NSRC), .ADDR_W(8)) u_dut (
    .pclk(clk), .presetn(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .srcIrq(src), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] rd;
    busRead(a, rd);
    check(tag, rd, exp);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic tReset();
    check("R1 irqOut after reset", irqOut, 0);
    check("R10 pready", pready, 1);
    check("R10 pslverr", pslverr, 0);
    readCheck("R1 enable lo", 8'h00, 0);
    readCheck("R1 enable hi", 8'h04, 0);
    readCheck("R1 suppress lo", 8'h08, 0);
    readCheck("R1 suppress hi", 8'h0C, 0);
    readCheck("R1 enabled view lo", 8'h20, 0);
    readCheck("R1 qualified view hi", 8'h34, 0);
  endtask

  task automatic tDiscover();
    busWrite(8'h00, 32'hFFFF_FFFF);
    busWrite(8'h04, 32'hFFFF_FFFF);
    busWrite(8'h08, 32'hFFFF_FFFF);
    busWrite(8'h0C, 32'hFFFF_FFFF);
    readCheck("R7 enable lo all built", 8'h00, 32'hFFFF_FFFF);
    readCheck("R7 enable hi trimmed", 8'h04, HI_BUILT);
    readCheck("R7 suppress lo all built", 8'h08, 32'hFFFF_FFFF);
    readCheck("R7 suppress hi trimmed", 8'h0C, HI_BUILT);
    busWrite(8'h08, 32'h0);
    busWrite(8'h0C, 32'h0);
    readCheck("R3 suppress lo cleared", 8'h08, 0);
  endtask

  task automatic tEnableFields();
    src = '0;
    busWrite(8'h00, 32'h0000_0005);
    busWrite(8'h04, 32'h0000_0082);
    readCheck("R2 enable lo readback", 8'h00, 32'h0000_0005);
    readCheck("R2 enable hi readback", 8'h04, 32'h0000_0082);
    src[1] = 1'b1; src[2] = 1'b1; src[33] = 1'b1;
    settle();
    readCheck("R2 R5 enabled view lo", 8'h20, 32'h0000_0004);
    readCheck("R2 R5 enabled view hi", 8'h24, 32'h0000_0002);
    readCheck("R4 qualified view hi", 8'h34, 32'h0000_0002);
    src[2] = 1'b0; src[33] = 1'b0;
    settle();
    check("R2 disabled line cannot raise irqOut", irqOut, 0);
    src = '0;
  endtask

  task automatic tSyncLatency();
    busWrite(8'h00, 32'hFFFF_FFFF);
    src = '0;
    settle();
    check("R8 idle", irqOut, 0);
    @(negedge clk);
    src[3] = 1'b1;
    @(negedge clk);
    check("R8 one edge after rise", irqOut, 0);
    @(negedge clk);
    check("R8 two edges after rise", irqOut, 1);
    src[3] = 1'b0;
    @(negedge clk);
    check("R8 one edge after fall", irqOut, 1);
    @(negedge clk);
    check("R8 two edges after fall", irqOut, 0);
  endtask

  task automatic tMask();
    busWrite(8'h00, 32'hFFFF_FFFF);
    busWrite(8'h04, 32'hFFFF_FFFF);
    src = '0;
    src[3] = 1'b1;
    settle();
    check("R6 single line", irqOut, 1);
    busWrite(8'h08, 32'h0000_0008);
    check("R3 suppressed line drops output", irqOut, 0);
    readCheck("R4 qualified lo suppressed", 8'h30, 0);
    readCheck("R5 enabled view ignores suppress", 8'h20, 32'h0000_0008);
    src[35] = 1'b1;
    settle();
    check("R6 upper line drives output", irqOut, 1);
    readCheck("R4 qualified hi", 8'h34, 32'h0000_0008);
    busWrite(8'h0C, 32'h0000_0008);
    check("R3 upper suppress", irqOut, 0);
    readCheck("R5 enabled view hi", 8'h24, 32'h0000_0008);
    busWrite(8'h08, 32'h0);
    check("R6 OR after unsuppress", irqOut, 1);
    readCheck("R4 qualified lo", 8'h30, 32'h0000_0008);
    busWrite(8'h0C, 32'h0);
    src = '0;
    settle();
  endtask

  task automatic tLevel();
    busWrite(8'h00, 32'hFFFF_FFFF);
    src = '0;
    src[5] = 1'b1;
    settle();
    busWrite(8'h30, 32'hFFFF_FFFF);
    busWrite(8'h34, 32'hFFFF_FFFF);
    readCheck("R9 no clear by write", 8'h30, 32'h0000_0020);
    readCheck("R4 write to status leaves enable", 8'h00, 32'hFFFF_FFFF);
    repeat (5) @(negedge clk);
    check("R9 held while high", irqOut, 1);
    src[5] = 1'b0;
    settle();
    check("R9 falls with input", irqOut, 0);
    readCheck("R9 status clears", 8'h30, 0);
  endtask

  task automatic tUndefined();
    logic [31:0] rd;
    busWrite(8'h00, 32'hA5A5_A5A5);
    busWrite(8'h0C, 32'h0000_0011);
    busWrite(8'h10, 32'hFFFF_FFFF);
    busWrite(8'h2C, 32'hFFFF_FFFF);
    busWrite(8'h40, 32'hFFFF_FFFF);
    busWrite(8'hFC, 32'hFFFF_FFFF);
    busWrite(8'h01, 32'hFFFF_FFFF);
    busWrite(8'h0E, 32'h0);
    readCheck("R11 enable lo kept", 8'h00, 32'hA5A5_A5A5);
    readCheck("R11 suppress hi kept", 8'h0C, 32'h0000_0011);
    readCheck("R11 suppress lo kept", 8'h08, 0);
    readCheck("R11 undefined read 0x10", 8'h10, 0);
    readCheck("R11 undefined read 0x40", 8'h40, 0);
    readCheck("R11 unaligned read", 8'h01, 0);
    // R10: flags during an access phase
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = 8'h00;
    @(negedge clk);
    penable = 1'b1;
    #1 rd = prdata;
    check("R10 pready in access", pready, 1);
    check("R10 pslverr in access", pslverr, 0);
    check("R10 data valid in access", rd, 32'hA5A5_A5A5);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    busWrite(8'h0C, 32'h0);
  endtask

  task automatic tPhase();
    busWrite(8'h00, 32'h0);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'hFFFF_FFFF;
    @(negedge clk);
    psel = 1'b0; penable = 1'b1;
    @(negedge clk);
    penable = 1'b0; pwrite = 1'b0;
    readCheck("R12 setup-only and unselected cycles write nothing", 8'h00, 0);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    rstN = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; src = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tDiscover();
    tEnableFields();
    tSyncLatency();
    tMask();
    tLevel();
    tUndefined();
    tPhase();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
      $finish;
    end
  end

endmodule